// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder and Decoder

This block sits between a UART and an infrared transceiver. On the transmit side it reshapes the UART bit stream into infrared pulses. Every 0 bit, the start bit included, becomes one short active-high pulse at the start of its bit period. A 1 bit leaves the infrared line low. On the receive side it turns the pulses from the transceiver back into a UART-level stream. Each detected pulse drives the recovered data low for one full bit time.

Bit timing comes from a 16x oversample enable that is high for one clock, sixteen times per bit. A 3-bit select chooses the transmit pulse width. Code 0 gives 3/16 of the bit period. Codes 1 to 7 give fixed widths counted in system clocks, so that a short pulse of about 1.6 µs can be produced at 20 MHz whatever the bit rate. On receive, a pulse of any width is taken as a 0, down to a single clock.

Top module: `irda_sir_codec`

## Requirements
- R1: While and after the active-low synchronous reset, `ir_tx` is low and `uart_rxd` is high until new stimulus arrives.
- R2: A 0 bit on `uart_txd` gives exactly one high pulse on `ir_tx`. The pulse rises in the clock after the first `tick16` that follows a change on `uart_txd`. If 0 bits repeat with no change, each further pulse rises 16 ticks after the previous one.
- R3: A bit period in which `uart_txd` is 1 produces no pulse: `ir_tx` only rises when `uart_txd` was 0 in the clock before.
- R4: With `width_sel` = 0, each pulse lasts exactly 3 `tick16` periods.
- R5: With `width_sel` = n, for n from 1 to 7, each pulse lasts exactly 8·2^n clocks. For example, n = 2 gives 32 clocks, which is 1.6 µs at 20 MHz.
- R6: A rising edge on `ir_rx` drives `uart_rxd` low after the third rising clock edge that follows the change. Two of these edges are synchroniser stages.
- R7: `uart_rxd` goes back high on the 16th `tick16` after the last detected rising edge. A new edge restarts this count.
- R8: A high level on `ir_rx` that lasts one clock is decoded as a 0 bit.
- R9: When `ir_tx` is looped back to `ir_rx`, `uart_rxd` sampled at the middle of each bit period reproduces the transmitted bit, for every `width_sel` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | One-clock enable, 16 per bit period |
| width_sel | input | 3 | Pulse width select: 0 = 3/16 bit, n = 8·2^n clocks |
| uart_txd | input | 1 | Serial data from the UART transmitter |
| ir_rx | input | 1 | Pulse input from the transceiver, active high |
| ir_tx | output | 1 | Pulse output to the transceiver, active high |
| uart_rxd | output | 1 | Recovered serial data to the UART receiver, idles high |

## Verification
The assertions assume three things about the inputs. `uart_txd` changes at most once per bit period and never in the clock of a tick. `width_sel` is held steady while a pulse is in flight. A fixed pulse width is shorter than one bit period. The stimulus meets all three. It moves `uart_txd` half a tick period away from any tick. It changes the select only between bytes, with the line idle. For each select it picks a tick spacing that gives a bit period longer than the chosen fixed width.

// File: rtl/irda_pkg.sv
// Shared types and constant helpers for the infrared pulse codec.
// Assumes: nothing beyond standard elaboration-time evaluation.
package irda_pkg;

    // Pulse length source chosen by the width select
    typedef enum logic {
        PW_FRACTION = 1'b0,
        PW_FIXED    = 1'b1
    } pw_mode_e;

    // Fixed pulse length in clocks for a nonzero select code
    function automatic int unsigned fixed_clks(input int unsigned base, input int unsigned code);
        return base << code;
    endfunction

endpackage

// File: rtl/irda_sync.sv
// Multi-stage synchroniser for an asynchronous single-bit input.
// Assumes: input may change at any time; output reset value is low (idle line).
module irda_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);

    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/irda_tx_shaper.sv
// Transmit shaper: tracks bit boundaries from the oversample tick and emits one
// active-high pulse per 0 bit, sized by the width select.
// Assumes: uart_txd changes at most once per bit and not in a tick clock;
// width_sel held while a pulse is in flight; fixed widths fit in one bit.
module irda_tx_shaper
    import irda_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int FRAC_TICKS    = 3,
    parameter int BASE_CLKS     = 8,
    parameter int SEL_W         = 3,
    parameter int CNT_W         = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [SEL_W-1:0] width_sel,
    input  logic             uart_txd,
    output logic             ir_tx
);

    localparam int PH_W = $clog2(TICKS_PER_BIT);

    logic [PH_W-1:0]  phase;
    logic             pend;
    logic             txd_prev;
    logic             txd_change;
    logic             bit_start;
    logic             pulse_on;
    logic             frac_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;
    logic             dec_en;
    pw_mode_e         sel_mode;

    assign txd_change = (uart_txd != txd_prev);
    assign bit_start  = tick && !txd_change &&
                        (pend || (phase == PH_W'(TICKS_PER_BIT - 1)));
    assign sel_mode   = (width_sel == '0) ? PW_FRACTION : PW_FIXED;
    assign load_val   = (sel_mode == PW_FRACTION) ? CNT_W'(FRAC_TICKS)
                                                  : (CNT_W'(BASE_CLKS) << width_sel);
    assign dec_en     = frac_q ? tick : 1'b1;

    // Track the bit phase: a data change arms a start, ticks advance the phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd_prev <= 1'b1;
            pend     <= 1'b0;
            phase    <= '0;
        end else begin
            txd_prev <= uart_txd;
            if (txd_change) begin
                pend <= 1'b1;
            end else if (tick) begin
                if (bit_start) begin
                    phase <= '0;
                    pend  <= 1'b0;
                end else begin
                    phase <= phase + 1'b1;
                end
            end
        end
    end

    // Start, time and end one pulse per 0 bit with a reloading down-counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_on <= 1'b0;
            frac_q   <= 1'b1;
            cnt      <= '0;
        end else if (bit_start && !uart_txd) begin
            pulse_on <= 1'b1;
            frac_q   <= (sel_mode == PW_FRACTION);
            cnt      <= load_val;
        end else if (pulse_on && dec_en) begin
            if (cnt == CNT_W'(1)) pulse_on <= 1'b0;
            cnt <= cnt - 1'b1;
        end
    end

    assign ir_tx = pulse_on;

    // R2
    tx_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ir_tx) |-> $past(tick));

    // R3
    tx_rise_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ir_tx) |-> !$past(uart_txd));

    // R4
    tx_frac_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_on && frac_q) |-> (cnt <= CNT_W'(FRAC_TICKS)));

    // R5
    tx_cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_on |-> (cnt != '0));

endmodule

// File: rtl/irda_rx_stretch.sv
// Receive stretcher: detects rising edges of the synchronised pulse input and
// holds the recovered data low for one bit time of ticks after each edge.
// Assumes: ir_sync is already synchronous to clk.
module irda_rx_stretch #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ir_sync,
    output logic uart_rxd
);

    localparam int CW = $clog2(TICKS_PER_BIT + 1);

    logic          sync_prev;
    logic          rise;
    logic [CW-1:0] cnt;

    assign rise = ir_sync && !sync_prev;

    // Remember the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync_prev <= 1'b0;
        else        sync_prev <= ir_sync;
    end

    // Reload on every edge, count ticks down to release the line
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (rise)               cnt <= CW'(TICKS_PER_BIT);
        else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign uart_rxd = (cnt == '0);

    // R7
    rx_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (cnt == CW'(TICKS_PER_BIT)));

    // R6
    rx_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uart_rxd) |-> $past(rise));

    // R7
    rx_release_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uart_rxd) |-> $past(tick));

endmodule

// File: rtl/irda_sir_codec.sv
// Top of the infrared pulse codec: transmit shaper plus synchronised receive
// stretcher. Assumes tick16 pulses for one clock, sixteen times per bit.
module irda_sir_codec
    import irda_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int FRAC_TICKS    = 3,
    parameter int BASE_CLKS     = 8,
    parameter int SEL_W         = 3,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic [SEL_W-1:0] width_sel,
    input  logic             uart_txd,
    input  logic             ir_rx,
    output logic             ir_tx,
    output logic             uart_rxd
);

    localparam int MAX_CLKS = int'(fixed_clks(BASE_CLKS, (1 << SEL_W) - 1));
    localparam int CNT_W    = $clog2(MAX_CLKS) + 1;

    logic ir_sync;

    irda_tx_shaper #(
        .TICKS_PER_BIT(TICKS_PER_BIT),
        .FRAC_TICKS   (FRAC_TICKS),
        .BASE_CLKS    (BASE_CLKS),
        .SEL_W        (SEL_W),
        .CNT_W        (CNT_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .width_sel(width_sel),
        .uart_txd (uart_txd),
        .ir_tx    (ir_tx)
    );

    irda_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (ir_rx),
        .d_out(ir_sync)
    );

    irda_rx_stretch #(
        .TICKS_PER_BIT(TICKS_PER_BIT)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .ir_sync (ir_sync),
        .uart_rxd(uart_rxd)
    );

endmodule

// File: tb/sim_irda_sir_codec.sv
module sim_irda_sir_codec;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [2:0] width_sel = 3'd0;
    logic       uart_txd = 1'b1;
    logic       ir_drv = 1'b0;
    logic       lb_en = 1'b0;
    logic       ir_rx;
    logic       ir_tx;
    logic       uart_rxd;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int per = 8;
    bit done = 1'b0;

    // pulse monitor storage
    int  n_pulse = 0;
    int  rise_at [0:15];
    int  width_of [0:15];
    int  cur_rise = 0;
    logic tx_prev = 1'b0;

    assign ir_rx = lb_en ? ir_tx : ir_drv;

    always #4 clk = ~clk;

    irda_sir_codec u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick16   (tick16),
        .width_sel(width_sel),
        .uart_txd (uart_txd),
        .ir_rx    (ir_rx),
        .ir_tx    (ir_tx),
        .uart_rxd (uart_rxd)
    );

    // cycle count, tick generation and pulse monitor, all at the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        tick16 = ((cyc % per) == 0);
        if (ir_tx && !tx_prev) cur_rise = cyc;
        if (!ir_tx && tx_prev && n_pulse < 16) begin
            rise_at[n_pulse]  = cur_rise;
            width_of[n_pulse] = cyc - cur_rise;
            n_pulse = n_pulse + 1;
        end
        tx_prev = ir_tx;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // vectors: {width_sel, byte, tick period}
    localparam logic [18:0] VEC [0:9] = '{
        {3'd0, 8'h55, 8'd8},
        {3'd0, 8'h00, 8'd8},
        {3'd0, 8'hFF, 8'd8},
        {3'd1, 8'hA3, 8'd8},
        {3'd2, 8'h3C, 8'd8},
        {3'd3, 8'h81, 8'd16},
        {3'd4, 8'h0F, 8'd16},
        {3'd5, 8'hC6, 8'd32},
        {3'd6, 8'h29, 8'd64},
        {3'd7, 8'h70, 8'd80}
    };

    task automatic send_byte(input logic [2:0] sel, input logic [7:0] data, input int p);
        logic [9:0] frame;
        int exp_rise [0:15];
        int n_zero;
        int exp_w;
        per = p;
        width_sel = sel;
        step(2 * p);
        n_pulse = 0;
        n_zero = 0;
        frame = {1'b1, data, 1'b0};
        exp_w = (sel == 3'd0) ? 3 * p : (8 << sel);
        for (int b = 0; b < 10; b++) begin
            while ((cyc % per) != per / 2) step(1);
            uart_txd = frame[b];
            if (!frame[b]) begin
                exp_rise[n_zero] = cyc + per / 2 + 1;
                n_zero++;
            end
            step(8 * p);
            // R9 loopback mid-bit sample
            chk(uart_rxd == frame[b], "R9 loopback bit", int'(uart_rxd), int'(frame[b]));
            step(8 * p - 1);
        end
        step(32 * p);
        // R2 / R3 one pulse per 0 bit, none for 1 bits
        chk(n_pulse == n_zero, "R2 R3 pulse count", n_pulse, n_zero);
        for (int i = 0; i < n_zero && i < n_pulse; i++) begin
            // R2 pulse position
            chk(rise_at[i] == exp_rise[i], "R2 pulse start", rise_at[i], exp_rise[i]);
            if (sel == 3'd0)
                chk(width_of[i] == exp_w, "R4 width 3/16", width_of[i], exp_w);
            else
                chk(width_of[i] == exp_w, "R5 fixed width", width_of[i], exp_w);
        end
    endtask

    initial begin
        step(5);
        // R1 reset state
        chk(ir_tx == 1'b0, "R1 ir_tx in reset", int'(ir_tx), 0);
        chk(uart_rxd == 1'b1, "R1 uart_rxd in reset", int'(uart_rxd), 1);
        rst_n = 1'b1;
        step(40);
        chk(ir_tx == 1'b0, "R1 ir_tx after reset", int'(ir_tx), 0);
        chk(uart_rxd == 1'b1, "R1 uart_rxd after reset", int'(uart_rxd), 1);

        // table walk with loopback
        lb_en = 1'b1;
        for (int v = 0; v < 10; v++)
            send_byte(VEC[v][18:16], VEC[v][15:8], int'(VEC[v][7:0]));
        lb_en = 1'b0;

        // R6 / R8: one-clock glitch decodes as 0 with fixed latency
        per = 8;
        step(40);
        ir_drv = 1'b1;
        step(1);
        ir_drv = 1'b0;
        step(1);
        chk(uart_rxd == 1'b1, "R6 not yet low", int'(uart_rxd), 1);
        step(1);
        chk(uart_rxd == 1'b0, "R8 glitch gives 0", int'(uart_rxd), 0);
        // R7 held for 16 ticks then released
        step(14 * 8);
        chk(uart_rxd == 1'b0, "R7 still low", int'(uart_rxd), 0);
        step(3 * 8 + 2);
        chk(uart_rxd == 1'b1, "R7 released", int'(uart_rxd), 1);

        // R7 restart on a new edge
        step(20);
        ir_drv = 1'b1;
        step(2);
        ir_drv = 1'b0;
        step(10 * 8);
        ir_drv = 1'b1;
        step(2);
        ir_drv = 1'b0;
        step(10 * 8);
        chk(uart_rxd == 1'b0, "R7 restarted stretch", int'(uart_rxd), 0);
        step(8 * 8);
        chk(uart_rxd == 1'b1, "R7 release after restart", int'(uart_rxd), 1);

        // R1 reset mid-pulse clears both outputs
        width_sel = 3'd7;
        while ((cyc % per) != per / 2) step(1);
        uart_txd = 1'b0;
        ir_drv = 1'b1;
        step(3 * per);
        rst_n = 1'b0;
        uart_txd = 1'b1;
        ir_drv = 1'b0;
        step(2);
        chk(ir_tx == 1'b0, "R1 ir_tx cleared", int'(ir_tx), 0);
        chk(uart_rxd == 1'b1, "R1 uart_rxd cleared", int'(uart_rxd), 1);
        rst_n = 1'b1;
        step(4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            #1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule